// File: doc/BRIEF.md
# Load/Store Execution Unit with Base-Register Update

This unit executes the memory-access instructions of a 64-bit processor. From one instruction word and the register values it works out an effective address, either base plus a sign-extended 32-bit offset or base plus a second register. It then issues one single-beat request on a synchronous memory port and waits for the memory's ready response. Loads return 8, 16, 32 or 64 bits, sign- or zero-extended to the full word. Stores send a register's value to memory. Either kind can write the effective address back into the base register after the access.

Memory is big-endian. The port carries the full effective address together with byte strobes for the lanes of an 8-byte doubleword. An access whose address is not a multiple of its size is rejected: the unit raises a fault pulse and makes no memory request and no register write. The register file sits outside the unit. The unit drives its read indices straight from the instruction word and takes the read values in the same cycle. It writes results back through two write ports: one for load data and one for the updated base.

Top module: `ldst_unit`

## Requirements
- R1: An instruction is taken only when issue_valid is high, the unit is not busy, bits 63:61 equal 3'b101, bit 60 is 0 and bits 53:50 are all 0. Any other instruction produces no request, no busy, no fault and no register write.
- R2: Subclass bits 59:56 decode as follows. Bit 59 set means store. Bit 58 set means indexed. Bits 57:56 give the size: 0 is 64 bits, 1 is 32, 2 is 16, 3 is 8. So 0..3 are displacement loads, 4..7 indexed loads, 8..11 displacement stores and 12..15 indexed stores. mem_we is 1 for stores and 0 for loads.
- R3: The register indices are rb = bits 49:44, ra = bits 43:38 and rd = bits 37:32, and rf_*_idx show them combinationally. The effective address is ra + sign-extended bits 31:0 for displacement forms, ra + rb for indexed loads and ra + rd for indexed stores.
- R4: One cycle after an instruction is taken, mem_req and busy are high and mem_addr carries the effective address. These stay unchanged up to and including the first cycle with mem_ready high, and busy and mem_req are low in the cycle after it.
- R5: mem_be[i] enables data bits 8i+7:8i. An access of n bytes at byte offset o = addr[2:0] enables lanes 7-o down to 8-o-n. A store places the low n bytes of rb in those lanes, most significant byte at the lowest address, with all other data bits 0. mem_wdata is 0 for loads.
- R6: A load takes its value from the same lanes in the same byte order. It sign-extends the value when bit 55 is 1 and zero-extends it when bit 55 is 0. The result goes to register rd on the load write port (ld_we, ld_idx, ld_data) in the cycle mem_ready is seen.
- R7: When update bit 54 is set, the effective address is written to register ra on the base write port (base_we, base_idx, base_data) in the cycle mem_ready is seen. This applies to loads and to stores. A store never raises ld_we.
- R8: For a load with the update bit set and rd equal to ra, the load write port performs the write and base_we stays low.
- R9: A taken instruction whose effective address is not a multiple of its size pulses align_fault high for one cycle, one cycle after it is taken. It raises neither mem_req nor busy and causes no register write.
- R10: An issue presented while busy is ignored. The pending request keeps its address and no second request follows it.
- R11: After reset, busy, mem_req, align_fault, ld_we and base_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| issue_insn | input | 64 | Instruction word |
| rf_ra_idx | output | 6 | Register-file read index for the base |
| rf_rb_idx | output | 6 | Register-file read index for rb |
| rf_rd_idx | output | 6 | Register-file read index for rd |
| ra_val | input | 64 | Value of the base register |
| rb_val | input | 64 | Value of rb (index for loads, data for stores) |
| rd_val | input | 64 | Value of rd (index for indexed stores) |
| busy | output | 1 | An access is outstanding |
| align_fault | output | 1 | One-cycle pulse for a misaligned access |
| mem_req | output | 1 | Memory request valid |
| mem_addr | output | 64 | Effective address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 8 | Byte-lane strobes |
| mem_wdata | output | 64 | Store data, lane aligned |
| mem_rdata | input | 64 | Load data from memory |
| mem_ready | input | 1 | Memory completes the request this cycle |
| ld_we | output | 1 | Load result write enable |
| ld_idx | output | 6 | Load result register index |
| ld_data | output | 64 | Extended load result |
| base_we | output | 1 | Base update write enable |
| base_idx | output | 6 | Base register index |
| base_data | output | 64 | Updated base value |

## Verification
One register separates a taken instruction from its memory request or its fault pulse, so the bench checks mem_req, mem_addr, the strobes, the write data and align_fault at the first falling edge after the issuing edge. The register writes are combinational in the ready cycle, so the bench raises mem_ready at a falling edge and samples both write ports 1 ns later. Busy and mem_req must be low one edge after that. During random ready delays the bench re-checks that the request is stable every cycle, sometimes while it presents a competing issue. For ignored instructions it looks at every output one edge after the issue.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int INSN_W    = 64;
    localparam int REG_IDX_W = 6;
    localparam int CLS_HI    = 63;
    localparam int CLS_LO    = 61;
    localparam int SUB_TOP   = 60;
    localparam int SUB_ST    = 59;
    localparam int SUB_IX    = 58;
    localparam int SZ_HI     = 57;
    localparam int SZ_LO     = 56;
    localparam int SGN_BIT   = 55;
    localparam int UPD_BIT   = 54;
    localparam int RSV_HI    = 53;
    localparam int RSV_LO    = 50;
    localparam int RB_HI     = 49;
    localparam int RB_LO     = 44;
    localparam int RA_HI     = 43;
    localparam int RA_LO     = 38;
    localparam int RD_HI     = 37;
    localparam int RD_LO     = 32;
    localparam int IMM_W     = 32;
    localparam int NSIZES    = 4;
    localparam logic [2:0] CLS_MEM = 3'b101;

    typedef enum logic [1:0] {
        SZ_FULL = 2'd0,
        SZ_HALFW = 2'd1,
        SZ_QUART = 2'd2,
        SZ_BYTE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic                 valid;
        logic                 store;
        logic                 indexed;
        acc_size_e            size;
        logic                 sgn;
        logic                 upd;
        logic [REG_IDX_W-1:0] ra;
        logic [REG_IDX_W-1:0] rd;
    } mem_op_t;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(NBYTES)
) (
    input  logic [INSN_W-1:0]    insn,
    input  logic [DATA_W-1:0]    ra_val,
    input  logic [DATA_W-1:0]    rb_val,
    input  logic [DATA_W-1:0]    rd_val,
    output mem_op_t              op,
    output logic [REG_IDX_W-1:0] rb_idx,
    output logic [DATA_W-1:0]    ea,
    output logic [DATA_W-1:0]    st_data,
    output logic                 misaligned
);
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] simm;
    logic [OFF_W-1:0]  amask;

    always_comb begin
        op.valid   = (insn[CLS_HI:CLS_LO] == CLS_MEM) && !insn[SUB_TOP]
                     && (insn[RSV_HI:RSV_LO] == '0);
        op.store   = insn[SUB_ST];
        op.indexed = insn[SUB_IX];
        op.size    = acc_size_e'(insn[SZ_HI:SZ_LO]);
        op.sgn     = insn[SGN_BIT];
        op.upd     = insn[UPD_BIT];
        op.ra      = insn[RA_HI:RA_LO];
        op.rd      = insn[RD_HI:RD_LO];
        rb_idx     = insn[RB_HI:RB_LO];

        simm = {{(DATA_W-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};
        if (!op.indexed)
            offset = simm;
        else if (op.store)
            offset = rd_val;
        else
            offset = rb_val;
        ea      = ra_val + offset;
        st_data = rb_val;

        amask      = OFF_W'((NBYTES >> op.size) - 1);
        misaligned = |(ea[OFF_W-1:0] & amask);
    end
endmodule

// File: rtl/ldst_lanes.sv
module ldst_lanes
    import ldst_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(NBYTES)
) (
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] st_data,
    output logic [NBYTES-1:0] be,
    output logic [DATA_W-1:0] wdata,
    output logic [OFF_W-1:0]  shift
);
    int                nb;
    int                low_lane;
    logic [DATA_W-1:0] dmask;

    always_comb begin
        nb       = NBYTES >> size;
        low_lane = NBYTES - int'(offset) - nb;
        shift    = OFF_W'(low_lane);
        if (nb == NBYTES)
            dmask = '1;
        else
            dmask = (DATA_W'(1) << (8 * nb)) - DATA_W'(1);
        wdata = (st_data & dmask) << {shift, 3'b000};
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign be[i] = (i >= low_lane) && (i < low_lane + nb);
    end
endmodule

// File: rtl/ldst_extend.sv
module ldst_extend
    import ldst_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(NBYTES)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  shift,
    input  acc_size_e         size,
    input  logic              sgn,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] cand [NSIZES];

    assign raw = rdata >> {shift, 3'b000};

    for (genvar z = 0; z < NSIZES; z++) begin : g_size
        localparam int W = DATA_W >> z;
        if (z == 0) begin : g_full
            assign cand[z] = raw;
        end else begin : g_part
            assign cand[z] = {{(DATA_W-W){sgn & raw[W-1]}}, raw[W-1:0]};
        end
    end

    assign value = cand[size];
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [INSN_W-1:0]    issue_insn,
    output logic [REG_IDX_W-1:0] rf_ra_idx,
    output logic [REG_IDX_W-1:0] rf_rb_idx,
    output logic [REG_IDX_W-1:0] rf_rd_idx,
    input  logic [DATA_W-1:0]    ra_val,
    input  logic [DATA_W-1:0]    rb_val,
    input  logic [DATA_W-1:0]    rd_val,
    output logic                 busy,
    output logic                 align_fault,
    output logic                 mem_req,
    output logic [DATA_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic [NBYTES-1:0]    mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 ld_we,
    output logic [REG_IDX_W-1:0] ld_idx,
    output logic [DATA_W-1:0]    ld_data,
    output logic                 base_we,
    output logic [REG_IDX_W-1:0] base_idx,
    output logic [DATA_W-1:0]    base_data
);
    typedef struct packed {
        logic                 busy;
        logic                 fault;
        logic                 we;
        logic                 sgn;
        logic                 upd;
        acc_size_e            size;
        logic [REG_IDX_W-1:0] ra;
        logic [REG_IDX_W-1:0] rd;
        logic [OFF_W-1:0]     shift;
        logic [NBYTES-1:0]    be;
        logic [DATA_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
    } unit_state_t;

    unit_state_t st_d, st_q;

    mem_op_t           op;
    logic [DATA_W-1:0] ea;
    logic [DATA_W-1:0] st_data;
    logic              misaligned;
    logic [NBYTES-1:0] lane_be;
    logic [DATA_W-1:0] lane_wdata;
    logic [OFF_W-1:0]  lane_shift;
    logic [DATA_W-1:0] ext_value;
    logic              accept;
    logic              done;

    ldst_decode #(.DATA_W(DATA_W)) i_decode (
        .insn       (issue_insn),
        .ra_val     (ra_val),
        .rb_val     (rb_val),
        .rd_val     (rd_val),
        .op         (op),
        .rb_idx     (rf_rb_idx),
        .ea         (ea),
        .st_data    (st_data),
        .misaligned (misaligned)
    );

    ldst_lanes #(.DATA_W(DATA_W)) i_lanes (
        .offset  (ea[OFF_W-1:0]),
        .size    (op.size),
        .st_data (st_data),
        .be      (lane_be),
        .wdata   (lane_wdata),
        .shift   (lane_shift)
    );

    ldst_extend #(.DATA_W(DATA_W)) i_extend (
        .rdata (mem_rdata),
        .shift (st_q.shift),
        .size  (st_q.size),
        .sgn   (st_q.sgn),
        .value (ext_value)
    );

    assign rf_ra_idx = op.ra;
    assign rf_rd_idx = op.rd;

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        accept     = issue_valid && !st_q.busy && op.valid;
        done       = st_q.busy && mem_ready;
        if (accept) begin
            if (misaligned) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.busy  = 1'b1;
                st_d.we    = op.store;
                st_d.sgn   = op.sgn;
                st_d.upd   = op.upd;
                st_d.size  = op.size;
                st_d.ra    = op.ra;
                st_d.rd    = op.rd;
                st_d.shift = lane_shift;
                st_d.be    = lane_be;
                st_d.addr  = ea;
                st_d.wdata = op.store ? lane_wdata : '0;
            end
        end else if (done) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy        = st_q.busy;
    assign align_fault = st_q.fault;
    assign mem_req     = st_q.busy;
    assign mem_addr    = st_q.addr;
    assign mem_we      = st_q.we;
    assign mem_be      = st_q.be;
    assign mem_wdata   = st_q.wdata;

    assign ld_we     = done && !st_q.we;
    assign ld_idx    = st_q.rd;
    assign ld_data   = ext_value;
    assign base_we   = done && st_q.upd && !(!st_q.we && (st_q.rd == st_q.ra));
    assign base_idx  = st_q.ra;
    assign base_data = st_q.addr;

    // R4: request held steady until ready
    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be));

    // R4: busy clears after completion
    p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready |=> !busy);

    // R5: strobes form a power-of-two group
    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1) || ($countones(mem_be) == 2)
                 || ($countones(mem_be) == 4) || ($countones(mem_be) == NBYTES));

    // R9: issued addresses are aligned to the strobe count
    p_addr_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) != 0)
                 && ((int'(mem_addr[OFF_W-1:0]) % $countones(mem_be)) == 0));

    // R9: fault cycle has no write-back and no request
    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> !ld_we && !base_we && !mem_req);

    // R8: never two writes to the same register
    p_one_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we && base_we |-> ld_idx != base_idx);
endmodule

// File: tb/test_ldst_unit.sv
`timescale 1ns/1ps
module test_ldst_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [63:0] issue_insn = '0;
    logic [5:0]  rf_ra_idx, rf_rb_idx, rf_rd_idx;
    logic [63:0] ra_val = '0, rb_val = '0, rd_val = '0;
    logic        busy, align_fault, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [7:0]  mem_be;
    logic [63:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        ld_we, base_we;
    logic [5:0]  ld_idx, base_idx;
    logic [63:0] ld_data, base_data;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ldst_unit i_ldst_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_insn(issue_insn),
        .rf_ra_idx(rf_ra_idx), .rf_rb_idx(rf_rb_idx), .rf_rd_idx(rf_rd_idx),
        .ra_val(ra_val), .rb_val(rb_val), .rd_val(rd_val),
        .busy(busy), .align_fault(align_fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .base_we(base_we), .base_idx(base_idx), .base_data(base_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_insn(input logic [3:0] sub, input bit sg, input bit up,
                                            input logic [5:0] rb, input logic [5:0] ra,
                                            input logic [5:0] rd, input logic [31:0] imm);
        logic [63:0] w;
        w = '0;
        w[63:61] = 3'b101;
        w[59:56] = sub;
        w[55] = sg;
        w[54] = up;
        w[49:44] = rb;
        w[43:38] = ra;
        w[37:32] = rd;
        w[31:0] = imm;
        return w;
    endfunction

    function automatic logic [7:0] exp_be(input int o, input int n);
        logic [7:0] b;
        b = '0;
        for (int k = 0; k < n; k++) b[7-o-k] = 1'b1;
        return b;
    endfunction

    function automatic logic [63:0] exp_wdata(input logic [63:0] v, input int o, input int n);
        logic [63:0] w;
        w = '0;
        for (int k = 0; k < n; k++) w[(7-o-k)*8 +: 8] = v[(n-1-k)*8 +: 8];
        return w;
    endfunction

    function automatic logic [63:0] exp_load(input logic [63:0] rd_in, input int o, input int n, input bit sg);
        logic [63:0] v;
        v = '0;
        for (int k = 0; k < n; k++) v[(n-1-k)*8 +: 8] = rd_in[(7-o-k)*8 +: 8];
        if (sg && n < 8 && v[n*8-1])
            for (int j = n*8; j < 64; j++) v[j] = 1'b1;
        return v;
    endfunction

    task automatic run_op(input logic [63:0] insn, input logic [63:0] rav, input logic [63:0] rbv,
                          input logic [63:0] rdv, input int delay, input bit intrude,
                          input logic [63:0] rdata);
        bit st, ix, sg, up, flt;
        int n, o;
        logic [5:0] ra_i, rd_i, rb_i;
        logic [63:0] ea, held;
        st = insn[59]; ix = insn[58]; sg = insn[55]; up = insn[54];
        n = 8 >> insn[57:56];
        rb_i = insn[49:44]; ra_i = insn[43:38]; rd_i = insn[37:32];
        if (!ix) ea = rav + {{32{insn[31]}}, insn[31:0]};
        else if (st) ea = rav + rdv;
        else ea = rav + rbv;
        o = int'(ea[2:0]);
        flt = (ea % 64'(n)) != 0;

        @(negedge clk);
        issue_valid = 1'b1; issue_insn = insn;
        ra_val = rav; rb_val = rbv; rd_val = rdv;
        #1;
        chk(rf_ra_idx == ra_i && rf_rb_idx == rb_i && rf_rd_idx == rd_i, "R3 read indices",
            {46'd0, rf_ra_idx, rf_rb_idx, rf_rd_idx}, {46'd0, ra_i, rb_i, rd_i});
        @(negedge clk);
        issue_valid = 1'b0;
        if (flt) begin
            chk(align_fault == 1'b1, "R9 fault pulse", 64'(align_fault), 64'd1);
            chk(!mem_req && !busy, "R9 no request", {62'd0, mem_req, busy}, 64'd0);
            @(negedge clk);
            chk(!align_fault && !mem_req && !ld_we && !base_we, "R9 quiet after fault",
                {60'd0, align_fault, mem_req, ld_we, base_we}, 64'd0);
            return;
        end
        chk(mem_req && busy && !align_fault, "R4 request raised", {61'd0, mem_req, busy, align_fault}, 64'd6);
        chk(mem_addr == ea, "R3 effective address", mem_addr, ea);
        chk(mem_we == st, "R2 write enable", 64'(mem_we), 64'(st));
        chk(mem_be == exp_be(o, n), "R5 byte strobes", 64'(mem_be), 64'(exp_be(o, n)));
        if (st)
            chk(mem_wdata == exp_wdata(rbv, o, n), "R5 store data", mem_wdata, exp_wdata(rbv, o, n));
        else
            chk(mem_wdata == '0, "R5 load wdata zero", mem_wdata, 64'd0);
        held = mem_addr;
        for (int d = 0; d < delay; d++) begin
            if (intrude) begin
                issue_valid = 1'b1;
                issue_insn = mk_insn(4'd0, 1'b0, 1'b1, 6'd1, 6'd2, 6'd3, 32'h0000_0100);
                ra_val = 64'h1000;
            end
            @(negedge clk);
            chk(mem_req && mem_addr == held, intrude ? "R10 busy issue ignored" : "R4 request held",
                mem_addr, held);
            chk(!ld_we && !base_we, "R4 no early write", {62'd0, ld_we, base_we}, 64'd0);
        end
        issue_valid = 1'b0;
        mem_rdata = rdata;
        mem_ready = 1'b1;
        #1;
        if (st) begin
            chk(!ld_we, "R7 store no load write", 64'(ld_we), 64'd0);
        end else begin
            chk(ld_we && ld_idx == rd_i, "R6 load write port", {57'd0, ld_we, ld_idx}, {57'd1, rd_i});
            chk(ld_data == exp_load(rdata, o, n, sg), "R6 load data", ld_data, exp_load(rdata, o, n, sg));
        end
        if (up && !st && rd_i == ra_i)
            chk(!base_we, "R8 load wins over update", 64'(base_we), 64'd0);
        else if (up)
            chk(base_we && base_idx == ra_i && base_data == ea, "R7 base update",
                base_data, ea);
        else
            chk(!base_we, "R7 no update", 64'(base_we), 64'd0);
        @(negedge clk);
        mem_ready = 1'b0;
        chk(!busy && !mem_req, "R4 busy cleared", {62'd0, busy, mem_req}, 64'd0);
        if (intrude) begin
            @(negedge clk);
            chk(!busy && !mem_req, "R10 no second request", {62'd0, busy, mem_req}, 64'd0);
        end
    endtask

    task automatic run_ignored(input logic [63:0] insn, input string req);
        @(negedge clk);
        issue_valid = 1'b1; issue_insn = insn;
        ra_val = 64'h3; rb_val = 64'h0; rd_val = 64'h0;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(!busy && !mem_req && !align_fault && !ld_we && !base_we, req,
            {59'd0, busy, mem_req, align_fault, ld_we, base_we}, 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !align_fault && !ld_we && !base_we, "R11 reset state",
            {59'd0, busy, mem_req, align_fault, ld_we, base_we}, 64'd0);

        // R1: wrong class, top subclass bit, reserved bits (all with misaligned EA)
        run_ignored({3'b100, 61'h0} | 64'h3, "R1 other class ignored");
        run_ignored(mk_insn(4'd1, 1'b0, 1'b1, 6'd0, 6'd1, 6'd2, 32'h0) | (64'd1 << 60), "R1 subclass bit 60 ignored");
        run_ignored(mk_insn(4'd0, 1'b0, 1'b1, 6'd0, 6'd1, 6'd2, 32'h0) | (64'd1 << 51), "R1 reserved bits ignored");

        // directed corners
        run_op(mk_insn(4'd3, 1'b1, 1'b0, 6'd0, 6'd4, 6'd5, 32'h0000_0007), 64'h1000, 0, 0, 0, 0,
               64'h0000_0000_0000_0080);            // R6 signed byte, lane 0
        run_op(mk_insn(4'd3, 1'b0, 1'b0, 6'd0, 6'd4, 6'd5, 32'h0000_0007), 64'h1000, 0, 0, 1, 0,
               64'h0000_0000_0000_0080);            // R6 unsigned byte
        run_op(mk_insn(4'd0, 1'b0, 1'b1, 6'd0, 6'd9, 6'd9, 32'hFFFF_FFF8), 64'h2000, 0, 0, 2, 1,
               64'h0123_4567_89AB_CDEF);            // R8 same reg, negative offset
        run_op(mk_insn(4'd10, 1'b0, 1'b1, 6'd7, 6'd8, 6'd1, 32'h0000_0006), 64'h3000, 64'h1234_5678_9ABC_DEF0,
               0, 1, 0, 64'h0);                     // R5 halfword store at offset 6
        run_op(mk_insn(4'd13, 1'b0, 1'b0, 6'd7, 6'd8, 6'd1, 32'h0), 64'h3000, 64'hCAFE_F00D_1122_3344,
               64'h4, 0, 0, 64'h0);                 // R3 indexed store uses rd
        run_op(mk_insn(4'd5, 1'b1, 1'b0, 6'd7, 6'd8, 6'd1, 32'h0), 64'h3000, 64'h4, 64'h100,
               0, 0, 64'h0000_0000_8000_0001);      // R3 indexed load uses rb
        run_op(mk_insn(4'd1, 1'b0, 1'b0, 6'd0, 6'd1, 6'd2, 32'h0000_0002), 64'h4000, 0, 0, 0, 0,
               64'h0);                              // R9 misaligned word

        for (int t = 0; t < 400; t++) begin
            logic [1:0] sz;
            logic [3:0] sub;
            logic [5:0] ra_i, rd_i, rb_i;
            logic [63:0] rav, rbv, rdv, msk;
            logic [31:0] imm;
            sz = 2'($urandom % 4);
            sub = {1'($urandom % 2), 1'($urandom % 2), sz};
            ra_i = 6'($urandom % 64);
            rd_i = ($urandom % 4 == 0) ? ra_i : 6'($urandom % 64);
            rb_i = 6'($urandom % 64);
            rav = {$urandom, $urandom};
            rbv = {$urandom, $urandom};
            rdv = {$urandom, $urandom};
            imm = $urandom;
            if ($urandom % 5 != 0) begin
                msk = ~(64'(8 >> sz) - 64'd1);
                rav &= msk; rbv &= msk; rdv &= msk; imm &= msk[31:0];
            end
            run_op(mk_insn(sub, 1'($urandom % 2), 1'($urandom % 2), rb_i, ra_i, rd_i, imm),
                   rav, rbv, rdv, int'($urandom % 4), 1'($urandom % 2), {$urandom, $urandom});
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule